// File: doc/BRIEF.md
# Triggered Capture Buffer Controller

This block manages the sample memory of a small on-chip logic analyzer. Each clock it may accept one record, made of a sample word and a repeat count from an upstream run-length encoder. While it is armed it writes these records into a ring in block RAM. It compares every accepted sample against a masked trigger pattern. When the pattern matches, the controller records where the trigger record landed and keeps capturing until a post-trigger limit is reached. It then stops, raises `done`, and opens a synchronous read port.

The read port uses logical addresses. The trigger record always reads back at the fixed address `TRIG_ADDR`. Older records appear at the addresses below it and newer records at the addresses above it, both modulo the depth. Where the ring was placed in physical memory does not matter to the reader. An optional clean pass runs before each capture and writes a marker byte into every byte of every word. Slots that never received a record then read back as the marker. All settings are compile-time parameters.

Top module: `trig_capture_buf`

## Requirements
- R1: In the armed state, an accepted record whose sample satisfies `(smp_data & TRIG_MASK) == TRIG_VAL` is the trigger. Accepted records that do not match leave the controller armed.
- R2: After capture, the trigger record reads back at address `TRIG_ADDR`. The record accepted k records before it reads back at `(TRIG_ADDR - k) mod DEPTH`, unless a later record has overwritten that slot.
- R3: The k-th record accepted after the trigger reads back at `(TRIG_ADDR + k) mod DEPTH`.
- R4: Capture ends when `POST_MAX` records have been accepted after the trigger. `done` reads 1 in the cycle after the edge that stores the last one.
- R5: Capture also ends when the next write would land on the trigger record, that is after `DEPTH-1` post-trigger records, if that limit comes before `POST_MAX`.
- R6: With `CLEAN_EN=1`, the clean pass takes exactly `DEPTH` cycles after the start edge. It writes `MARK` into every byte of every word. Records offered during the pass are neither stored nor treated as a trigger.
- R7: A `start` pulse in idle or done re-arms the controller and resets the write pointer. `start` has no effect during clean, armed or post-trigger capture.
- R8: A record with `smp_valid` low is neither stored nor treated as a trigger. In idle and done, valid records are ignored.
- R9: `rd_data` returns the word at logical address `rd_addr` one clock after the address is presented, while `done` is high. Otherwise it reads 0.
- R10: After reset the controller is idle, with `done` at 0 and `rd_data` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arm request pulse |
| smp_valid | input | 1 | Record on the sample inputs is valid this cycle |
| smp_data | input | DATA_W | Sample word, compared against the trigger |
| smp_rpt | input | RPT_W | Repeat count from the encoder, stored with the sample |
| rd_addr | input | ADDR_W | Logical readout address |
| done | output | 1 | Capture complete, readout valid |
| rd_data | output | RPT_W+DATA_W | Stored record `{rpt, data}`, one cycle after `rd_addr` |

## Verification
On every cycle the embedded assertions check the state rules:
- an armed controller stays armed without a valid match;
- the clean pass cannot end early;
- a finished capture holds until `start`;
- the post-trigger count stays within its limit;
- a post-trigger write never lands on the trigger slot;
- the read port is silent outside done.

Only the bench's scenarios can show where each record ends up in the logical address space. The bench sweeps pre-trigger depths from 0 to 20, so that the ring wraps zero, one or more times. It interleaves invalid cycles and stray start pulses. It reads back the whole memory from two configurations, one stopped by the post-trigger count and one stopped by ring wrap.

// File: rtl/tcb_pkg.sv
// Shared types for the triggered capture buffer.
// Assumes: nothing beyond IEEE 1800-2017.
package tcb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAN,
        ST_ARMED,
        ST_POST,
        ST_DONE
    } tcb_state_e;

endpackage

// File: rtl/tcb_match.sv
// Masked trigger comparator.
// Flags a sample whose masked bits equal the trigger value.
// Assumes: the mask and value are compile-time constants of the sample width.
module tcb_match #(
    parameter int              DATA_W    = 16,
    parameter logic [DATA_W-1:0] TRIG_MASK = '1,
    parameter logic [DATA_W-1:0] TRIG_VAL  = '0
) (
    input  logic [DATA_W-1:0] sample,
    output logic              hit
);

    // Compare the masked sample with the trigger value.
    always_comb begin
        hit = ((sample & TRIG_MASK) == TRIG_VAL);
    end

endmodule

// File: rtl/tcb_ram.sv
// Simple dual-port sample memory: one write port and one registered read port.
// The read register is cleared whenever reading is not enabled.
// Assumes: a memory array without reset, mapped to block RAM.
module tcb_ram #(
    parameter int ADDR_W = 10,
    parameter int WIDTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wa,
    input  logic [WIDTH-1:0]  wd,
    input  logic              re,
    input  logic [ADDR_W-1:0] ra,
    output logic [WIDTH-1:0]  q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WIDTH-1:0] mem [DEPTH];

    // Store a word on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[wa] <= wd;
        end
    end

    // Registered read; zero outside readout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (re) begin
            q <= mem[ra];
        end else begin
            q <= '0;
        end
    end

    assert_read_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> (q == '0));

endmodule

// File: rtl/tcb_fsm.sv
// Capture sequencer: idle, clean, armed ring writing, post-trigger capture, done.
// Records the physical slot of the trigger record.
// Stops on the post-trigger count or before wrapping onto the trigger slot.
// Assumes: POST_MAX fits in POST_W bits.
module tcb_fsm
    import tcb_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int POST_W   = 24,
    parameter int POST_MAX = 100000,
    parameter bit CLEAN_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              smp_valid,
    input  logic              hit,
    output tcb_state_e        state,
    output logic              wr_en,
    output logic              wr_mark,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] trig_phys
);

    localparam logic [POST_W-1:0] POST_LAST =
        (POST_MAX > 0) ? POST_W'(POST_MAX - 1) : '0;
    localparam tcb_state_e ARM_TARGET = CLEAN_EN ? ST_CLEAN : ST_ARMED;
    localparam tcb_state_e TRIG_TARGET = (POST_MAX == 0) ? ST_DONE : ST_POST;

    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] clean_ptr;
    logic [POST_W-1:0] post_cnt;
    logic              cnt_end;
    logic              wrap_end;

    // Post-trigger end conditions for the record written this cycle.
    always_comb begin
        cnt_end  = (post_cnt == POST_LAST);
        wrap_end = (ADDR_W'(wr_ptr + 1'b1) == trig_phys);
    end

    // State sequencing and pointer updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            wr_ptr    <= '0;
            clean_ptr <= '0;
            trig_phys <= '0;
            post_cnt  <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        wr_ptr    <= '0;
                        clean_ptr <= '0;
                        state     <= ARM_TARGET;
                    end
                end
                ST_CLEAN: begin
                    clean_ptr <= clean_ptr + 1'b1;
                    if (clean_ptr == '1) begin
                        state <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (smp_valid) begin
                        wr_ptr <= wr_ptr + 1'b1;
                        if (hit) begin
                            trig_phys <= wr_ptr;
                            post_cnt  <= '0;
                            state     <= TRIG_TARGET;
                        end
                    end
                end
                ST_POST: begin
                    if (smp_valid) begin
                        wr_ptr   <= wr_ptr + 1'b1;
                        post_cnt <= post_cnt + 1'b1;
                        if (cnt_end || wrap_end) begin
                            state <= ST_DONE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory write strobe, address and marker select.
    always_comb begin
        wr_mark = (state == ST_CLEAN);
        wr_en   = wr_mark || (smp_valid && ((state == ST_ARMED) || (state == ST_POST)));
        wr_addr = wr_mark ? clean_ptr : wr_ptr;
    end

    assert_hold_armed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !(smp_valid && hit)) |=> (state == ST_ARMED));

    assert_post_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST) |-> (post_cnt <= POST_LAST));

    assert_no_trig_overwrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POST && wr_en) |-> (wr_addr != trig_phys));

    assert_clean_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAN && clean_ptr != '1) |=> (state == ST_CLEAN));

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !start) |=> (state == ST_DONE));

endmodule

// File: rtl/trig_capture_buf.sv
// Triggered capture buffer controller (top).
// Stores {repeat, sample} records in a ring.
// Pins the trigger record to logical address TRIG_ADDR.
// Offers synchronous readout once capture is complete.
// Assumes: RPT_W + DATA_W is a multiple of 8 and TRIG_ADDR < 2**ADDR_W.
module trig_capture_buf
    import tcb_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                RPT_W     = 16,
    parameter int                ADDR_W    = 10,
    parameter int                TRIG_ADDR = 513,
    parameter int                POST_W    = 24,
    parameter int                POST_MAX  = 100000,
    parameter bit                CLEAN_EN  = 1'b1,
    parameter logic [7:0]        MARK      = 8'hEE,
    parameter logic [DATA_W-1:0] TRIG_MASK = 16'h0003,
    parameter logic [DATA_W-1:0] TRIG_VAL  = 16'h0002
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    smp_valid,
    input  logic [DATA_W-1:0]       smp_data,
    input  logic [RPT_W-1:0]        smp_rpt,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    done,
    output logic [RPT_W+DATA_W-1:0] rd_data
);

    localparam int                REC_W  = RPT_W + DATA_W;
    localparam int                NBYTES = REC_W / 8;
    localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_ADDR);

    tcb_state_e        state;
    logic              hit;
    logic              wr_en;
    logic              wr_mark;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] trig_phys;
    logic [ADDR_W-1:0] rd_phys;
    logic [REC_W-1:0]  wr_data;

    tcb_match #(
        .DATA_W    (DATA_W),
        .TRIG_MASK (TRIG_MASK),
        .TRIG_VAL  (TRIG_VAL)
    ) u_match (
        .sample (smp_data),
        .hit    (hit)
    );

    tcb_fsm #(
        .ADDR_W   (ADDR_W),
        .POST_W   (POST_W),
        .POST_MAX (POST_MAX),
        .CLEAN_EN (CLEAN_EN)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .smp_valid (smp_valid),
        .hit       (hit),
        .state     (state),
        .wr_en     (wr_en),
        .wr_mark   (wr_mark),
        .wr_addr   (wr_addr),
        .trig_phys (trig_phys)
    );

    // Choose the marker fill or the incoming record as write data.
    always_comb begin
        wr_data = wr_mark ? {NBYTES{MARK}} : {smp_rpt, smp_data};
    end

    // Map a logical read address onto the physical ring slot.
    always_comb begin
        rd_phys = ADDR_W'(rd_addr - TRIG_A + trig_phys);
        done    = (state == ST_DONE);
    end

    tcb_ram #(
        .ADDR_W (ADDR_W),
        .WIDTH  (REC_W)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .wa    (wr_addr),
        .wd    (wr_data),
        .re    (done),
        .ra    (rd_phys),
        .q     (rd_data)
    );

    assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_DONE) |-> !wr_en);

endmodule

// File: tb/trig_capture_buf_test.sv
module trig_capture_buf_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int TA         = 9;
    localparam int LIM_U      = 4;
    localparam int LIM_W      = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       v_u = 1'b0;
    logic       v_w = 1'b0;
    logic [7:0] sdata = '0;
    logic [7:0] srpt = '0;
    logic [3:0] rd_addr = '0;
    logic       done_u;
    logic       done_w;
    logic [15:0] rd_u;
    logic [15:0] rd_w;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_u [DEPTH];
    logic [15:0] exp_w [DEPTH];
    bit          val_w [DEPTH];
    int  idx, npre, pu, pw;
    bit  du, dw, trig_seen;
    logic [7:0] seq = 8'h01;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_capture_buf #(
        .DATA_W(8), .RPT_W(8), .ADDR_W(4), .TRIG_ADDR(TA), .POST_W(6),
        .POST_MAX(LIM_U), .CLEAN_EN(1'b1), .MARK(8'hEE),
        .TRIG_MASK(8'h81), .TRIG_VAL(8'h80)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(v_u),
        .smp_data(sdata), .smp_rpt(srpt), .rd_addr(rd_addr),
        .done(done_u), .rd_data(rd_u)
    );

    trig_capture_buf #(
        .DATA_W(8), .RPT_W(8), .ADDR_W(4), .TRIG_ADDR(TA), .POST_W(6),
        .POST_MAX(40), .CLEAN_EN(1'b0), .MARK(8'hEE),
        .TRIG_MASK(8'h81), .TRIG_VAL(8'h80)
    ) uut_wrap (
        .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(v_w),
        .smp_data(sdata), .smp_rpt(srpt), .rd_addr(rd_addr),
        .done(done_w), .rd_data(rd_w)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Offer one record to both instances and update the expected picture.
    task automatic feed(input bit v, input logic [7:0] d, input bit st, input bit is_trig);
        bit pdu, pdw;
        int la;
        logic [15:0] rec;
        pdu = du;
        pdw = dw;
        start = st;
        v_u = v;
        v_w = v;
        sdata = d;
        srpt = seq ^ 8'h5A;
        rec = {srpt, d};
        step();
        start = 1'b0;
        v_u = 1'b0;
        v_w = 1'b0;
        if (v) begin
            la = (((TA + idx - npre) % DEPTH) + DEPTH) % DEPTH;
            idx++;
            if (!du) begin
                exp_u[la] = rec;
                if (trig_seen) pu++;
                if (pu == LIM_U) du = 1'b1;
            end
            if (!dw) begin
                exp_w[la] = rec;
                val_w[la] = 1'b1;
                if (trig_seen) pw++;
                if (pw == LIM_W) dw = 1'b1;
            end
            if (is_trig) trig_seen = 1'b1;
            seq = seq + 8'd1;
        end
        // R4 count limit, R5 wrap limit, R1 trigger start
        check(done_u == du, "R4 done after post count", 16'(done_u), 16'(du));
        check(done_w == dw, "R5 done at ring wrap", 16'(done_w), 16'(dw));
        if (!pdu) check(rd_u == 16'h0, "R9 readout quiet before done", rd_u, 16'h0);
        if (!pdw) check(rd_w == 16'h0, "R9 readout quiet before done", rd_w, 16'h0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        // R10 reset state
        check(done_u == 1'b0, "R10 done after reset", 16'(done_u), 16'h0);
        check(done_w == 1'b0, "R10 done after reset", 16'(done_w), 16'h0);
        check(rd_u == 16'h0, "R10 rd_data after reset", rd_u, 16'h0);
        check(rd_w == 16'h0, "R10 rd_data after reset", rd_w, 16'h0);

        for (int n = 0; n <= 20; n++) begin
            npre = n;
            idx = 0; pu = 0; pw = 0;
            du = 1'b0; dw = 1'b0; trig_seen = 1'b0;
            for (int a = 0; a < DEPTH; a++) begin
                exp_u[a] = 16'hEEEE;
                exp_w[a] = 16'h0;
                val_w[a] = 1'b0;
            end
            // R7 arm from idle (first run) or done
            start = 1'b1;
            step();
            start = 1'b0;
            // R6 clean window: matching records offered to uut must be ignored
            for (int c = 0; c < DEPTH; c++) begin
                v_u = 1'b1;
                v_w = 1'b0;
                sdata = 8'h80;
                srpt = 8'hC3;
                start = (c == 3);
                step();
                check(done_u == 1'b0, "R6 no trigger during clean", 16'(done_u), 16'h0);
                check(rd_u == 16'h0, "R9 readout quiet while cleaning", rd_u, 16'h0);
            end
            v_u = 1'b0;
            start = 1'b0;
            // R8 gaps carry matching data with valid low; R7 stray start in armed
            for (int j = 0; j < n; j++) begin
                if (j % 3 == 1) feed(1'b0, 8'h80, 1'b0, 1'b0);
                feed(1'b1, seq & 8'h7F, (j == 2), 1'b0);
            end
            // R1 trigger record
            feed(1'b1, 8'h80 | ((seq << 1) & 8'h7E), 1'b0, 1'b1);
            // R3 post-trigger records, gaps, stray start (R7), extra after done (R8)
            for (int k = 0; k < 22; k++) begin
                if (k % 4 == 2) feed(1'b0, 8'h80, 1'b0, 1'b0);
                else            feed(1'b1, seq, (k == 1), 1'b0);
            end
            // R2 R3 R6 logical readout, one cycle latency (R9)
            for (int a = 0; a < DEPTH; a++) begin
                rd_addr = 4'(a);
                step();
                check(rd_u == exp_u[a], "R2 R3 R6 readout count-limited", rd_u, exp_u[a]);
                if (val_w[a])
                    check(rd_w == exp_w[a], "R2 R3 readout wrap-limited", rd_w, exp_w[a]);
            end
            rd_addr = 4'(TA);
            step();
            check(rd_u[7] == 1'b1 && rd_u[0] == 1'b0, "R2 trigger at fixed address",
                  rd_u, exp_u[TA]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule